// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog counter with a programmable overflow point. A 12-bit up-counter advances on every clock cycle in which the tick enable is high. When the value it is about to take equals the programmed stop value, the counter returns to zero and the block raises its overflow output for that one cycle. The stop value sits in a write-protected 32-bit register. A stop value of 1 gives the shortest interval, one tick. A stop value of 0 gives the longest, because the counter must pass through every one of its 4096 states before it wraps back to zero.

Software reaches the block through a small 32-bit register bus with an address, a write strobe, write data and combinational read data. Two word addresses are decoded: the stop register and the live counter. A write reaches either register only when the top byte of the write data holds the key 0x5A. Any other write is dropped. On read, the key byte and the reserved middle bits always return zero.

The block has two resets. The power-on reset clears everything, including the stop register. The synchronous soft reset clears only the counter and the overflow output, so the programmed timeout survives it.

Top module: `keyed_watchdog`

## Requirements
- R1: A write to word address 0 loads wdata[11:0] into the stop register only if wdata[31:24] equals 0x5A; a write carrying any other top byte leaves the stop register unchanged.
- R2: A read of address 0 returns the stop value in bits 11:0 and zero in bits 31:12, whatever key or reserved bits were written.
- R3: The counter increases by one on each clock edge where tick_en is high, and it holds its value on edges where tick_en, soft_rst and a keyed counter write are all low.
- R4: With stop value S from 1 to 4095 and tick_en held high, overflow is high for exactly the cycle after every S-th tick, and the counter reads 0 in that cycle.
- R5: With stop value 0, the counter passes through all 4096 states and overflow occurs once every 4096 ticks.
- R6: A write to word address 1 with top byte 0x5A loads wdata[11:0] into the counter. Without the key the counter is unaffected.
- R7: A high soft_rst clears the counter and the overflow output at the next edge and leaves the stop register unchanged.
- R8: While por_n is low, the stop register, the counter and the overflow output are all zero.
- R9: A read of address 1 returns the count in bits 11:0 and zero above. Addresses 2 and 3 read as zero, and writes to them change nothing.
- R10: In a single cycle, soft_rst takes precedence over a keyed counter write, and a keyed counter write takes precedence over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears all state |
| soft_rst | input | 1 | Synchronous soft reset, active high; clears counter and overflow |
| tick_en | input | 1 | Count enable for one clock cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 stop register, 1 counter |
| wdata | input | 32 | Write data, key code in bits 31:24 |
| rdata | output | 32 | Read data for the addressed register |
| overflow | output | 1 | One-cycle pulse when the count reaches the stop value |

## Verification
The hardest case to reach is the longest timeout. With a stop value of 0, overflow appears only after the counter has passed through all 4096 states and wrapped at the top. A test that starts from a fresh count must therefore run through two full periods. The bench sweeps stop values 1 to 20 plus 0x7FF, 0xFFF and 0, holds tick_en high and checks the count and the overflow after every edge against the tick number modulo the period. To reach the edge of the stop value directly, it also uses a keyed counter write to place the count one step below the stop value.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   // which register a bus address selects
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_STOP  = 2'd1,
      SEL_COUNT = 2'd2
   } reg_sel_e;

   localparam int KEY_WIDTH = 8;
   localparam logic [KEY_WIDTH-1:0] WRITE_KEY = 8'h5A;
endpackage

// File: rtl/kwdt_bus_decode.sv
module kwdt_bus_decode
   import kwdt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 2,
   parameter int STOP_OFS = 0,
   parameter int CNT_OFS  = 1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output reg_sel_e          sel,
   output logic              wr_stop,
   output logic              wr_cnt
);
   localparam logic [ADDR_W-1:0] STOP_A = ADDR_W'(STOP_OFS);
   localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFS);

   generate
      if (KEY_WIDTH > DATA_W) begin : g_bad_key
         $error("key code wider than the data bus");
      end
      if (STOP_OFS == CNT_OFS) begin : g_bad_ofs
         $error("stop and counter offsets collide");
      end
      if (STOP_OFS >= (1 << ADDR_W) || CNT_OFS >= (1 << ADDR_W)) begin : g_bad_range
         $error("register offset outside address range");
      end
   endgenerate

   logic key_ok;
   assign key_ok = (wdata[DATA_W-1 -: KEY_WIDTH] == WRITE_KEY);

   always_comb begin
      if (addr == STOP_A)     sel = SEL_STOP;
      else if (addr == CNT_A) sel = SEL_COUNT;
      else                    sel = SEL_NONE;
   end

   assign wr_stop = wr_en && key_ok && (sel == SEL_STOP);
   assign wr_cnt  = wr_en && key_ok && (sel == SEL_COUNT);
endmodule

// File: rtl/kwdt_stop_reg.sv
module kwdt_stop_reg #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] din,
   output logic [CNT_W-1:0] stop
);
   logic [CNT_W-1:0] stop_q;

   // only power-on reset touches this register
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)  stop_q <= '0;
      else if (wr) stop_q <= din;
   end

   assign stop = stop_q;

   // R1
   stop_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      !wr |=> $stable(stop_q));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             soft_rst,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] stop,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("counter must be at least 2 bits");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             ovf_q;
   logic             hit;

   // a stop of zero matches only after the natural wrap
   assign cnt_nxt = cnt_q + CNT_W'(1);
   assign hit     = (cnt_nxt == stop);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (soft_rst) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         ovf_q <= 1'b0;
      end else if (tick_en) begin
         cnt_q <= hit ? '0 : cnt_nxt;
         ovf_q <= hit;
      end else begin
         ovf_q <= 1'b0;
      end
   end

   assign count = cnt_q;
   assign ovf   = ovf_q;

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!soft_rst && !load && !tick_en) |=> $stable(cnt_q));
   // R4
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      ovf_q |-> (cnt_q == '0));
   // R4
   ovf_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
      ovf_q |-> $past(tick_en));
   // R7
   soft_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> (cnt_q == '0 && !ovf_q));
   // R10
   load_win_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!soft_rst && load) |=> (cnt_q == $past(load_val) && !ovf_q));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwdt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 2,
   parameter int CNT_W    = 12,
   parameter int STOP_OFS = 0,
   parameter int CNT_OFS  = 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_rst,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              overflow
);
   localparam int PAD_W = DATA_W - CNT_W;

   generate
      if (CNT_W > DATA_W - KEY_WIDTH) begin : g_bad_cnt
         $error("counter field overlaps key byte");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_stop, wr_cnt;
   logic [CNT_W-1:0] stop_val, cnt_val;
   logic             unused_rsvd;

   // key and reserved bits are not stored
   assign unused_rsvd = ^wdata[DATA_W-1:CNT_W];

   kwdt_bus_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .STOP_OFS(STOP_OFS), .CNT_OFS(CNT_OFS)
   ) u_dec (
      .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .sel(sel), .wr_stop(wr_stop), .wr_cnt(wr_cnt)
   );

   kwdt_stop_reg #(.CNT_W(CNT_W)) u_stop (
      .clk(clk), .por_n(por_n), .wr(wr_stop),
      .din(wdata[CNT_W-1:0]), .stop(stop_val)
   );

   kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .tick_en(tick_en),
      .load(wr_cnt), .load_val(wdata[CNT_W-1:0]), .stop(stop_val),
      .count(cnt_val), .ovf(overflow)
   );

   // read path zero-fills everything above the field
   logic [CNT_W-1:0] rd_field;
   always_comb begin
      case (sel)
         SEL_STOP:  rd_field = stop_val;
         SEL_COUNT: rd_field = cnt_val;
         default:   rd_field = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata = {{PAD_W{1'b0}}, rd_field};
      end else begin : g_nopad
         assign rdata = rd_field;
      end
   endgenerate

   // R1
   key_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wdata[DATA_W-1 -: KEY_WIDTH] != WRITE_KEY) |=> $stable(stop_val));
   // R7
   soft_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst && !wr_stop) |=> $stable(stop_val));
   // R6
   cnt_key_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wdata[DATA_W-1 -: KEY_WIDTH] != WRITE_KEY && !tick_en && !soft_rst)
      |=> $stable(cnt_val));
endmodule

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        overflow;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   always #4 clk = ~clk;   // 125 MHz

   keyed_watchdog dut (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .tick_en(tick_en),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .overflow(overflow)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic pulse_soft();
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   // run two periods of stop value s and compare every cycle
   task automatic sweep(input int s, input string req);
      int per, bad;
      logic [31:0] first_act, first_exp;
      per = (s == 0) ? 4096 : s;
      bad = 0; first_act = 0; first_exp = 0;
      wr(2'd0, 32'h5A00_0000 | 32'(s));
      pulse_soft();
      @(negedge clk);
      addr = 2'd1;
      tick_en = 1'b1;
      for (int k = 1; k <= 2 * per; k++) begin
         @(posedge clk);
         #1;
         if (rdata !== 32'(k % per) || overflow !== (k % per == 0)) begin
            if (bad == 0) begin
               first_act = {overflow, rdata[30:0]};
               first_exp = {(k % per == 0), 31'(k % per)};
            end
            bad++;
         end
      end
      @(negedge clk);
      tick_en = 1'b0;
      chk(req, first_act, first_exp);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin : main
      logic [31:0] v;
      int exp_cnt, bad;

      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 overflow in reset", {31'd0, overflow}, 32'd0);
      por_n = 1'b1;
      rd(2'd0, v); chk("R8 stop after por", v, 32'd0);
      rd(2'd1, v); chk("R8 count after por", v, 32'd0);

      // R1: unkeyed write to the stop register is dropped
      wr(2'd0, 32'hA500_0005);
      rd(2'd0, v); chk("R1 unkeyed stop write", v, 32'd0);
      wr(2'd0, 32'h5B00_0007);
      rd(2'd0, v); chk("R1 near-key stop write", v, 32'd0);
      // R1 R2: keyed write, key and reserved bits read back zero
      wr(2'd0, 32'h5AFF_F123);
      rd(2'd0, v); chk("R2 stop readback", v, 32'h0000_0123);

      // R3: irregular tick pattern, stop 0 so no wrap
      wr(2'd0, 32'h5A00_0000);
      pulse_soft();
      @(negedge clk);
      addr = 2'd1;
      exp_cnt = 0; bad = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         tick_en = (i % 3 == 0) || (i % 7 == 2);
         @(posedge clk);
         #1;
         if (tick_en) exp_cnt++;
         if (rdata !== 32'(exp_cnt)) bad++;
      end
      @(negedge clk);
      tick_en = 1'b0;
      chk("R3 gapped tick mismatches", 32'(bad), 32'd0);
      rd(2'd1, v); chk("R3 gapped tick total", v, 32'(exp_cnt));

      // R4 R5: overflow period sweep
      for (int s = 1; s <= 20; s++) sweep(s, "R4 period sweep");
      sweep(12'h7FF, "R4 period 0x7FF");
      sweep(12'hFFF, "R4 period 0xFFF");
      sweep(0, "R5 full-range period");

      // R6: keyed counter load, unkeyed ignored
      wr(2'd1, 32'h5A00_07FE);
      rd(2'd1, v); chk("R6 keyed count load", v, 32'h0000_07FE);
      wr(2'd1, 32'h0000_00AA);
      rd(2'd1, v); chk("R6 unkeyed count write", v, 32'h0000_07FE);
      run_ticks(2);
      rd(2'd1, v); chk("R6 count after load and ticks", v, 32'h0000_0800);

      // R4: load one below stop, one tick overflows
      wr(2'd0, 32'h5A00_0010);
      wr(2'd1, 32'h5A00_000F);
      @(negedge clk);
      addr = 2'd1; tick_en = 1'b1;
      @(posedge clk); #1;
      chk("R4 overflow at stop edge", {31'd0, overflow}, 32'd1);
      chk("R4 count zero at overflow", rdata, 32'd0);
      @(negedge clk);
      tick_en = 1'b0;
      #5 chk("R4 overflow single cycle", {31'd0, overflow}, 32'd0);

      // R7: soft reset clears count and overflow, keeps stop
      wr(2'd0, 32'h5A00_0001);
      @(negedge clk);
      tick_en = 1'b1; soft_rst = 1'b0;
      @(posedge clk); #1;
      chk("R7 overflow before soft reset", {31'd0, overflow}, 32'd1);
      @(negedge clk);
      soft_rst = 1'b1;
      @(posedge clk); #1;
      chk("R7 overflow cleared", {31'd0, overflow}, 32'd0);
      @(negedge clk);
      soft_rst = 1'b0; tick_en = 1'b0;
      wr(2'd0, 32'h5A00_0300);
      run_ticks(5);
      pulse_soft();
      rd(2'd1, v); chk("R7 count cleared", v, 32'd0);
      rd(2'd0, v); chk("R7 stop kept", v, 32'h0000_0300);

      // R10: keyed load beats tick, soft reset beats load
      @(negedge clk);
      addr = 2'd1; wdata = 32'h5A00_0123; wr_en = 1'b1; tick_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
      rd(2'd1, v); chk("R10 load over tick", v, 32'h0000_0123);
      @(negedge clk);
      addr = 2'd1; wdata = 32'h5A00_0456; wr_en = 1'b1; soft_rst = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; soft_rst = 1'b0;
      rd(2'd1, v); chk("R10 soft reset over load", v, 32'd0);

      // R9: unused addresses
      wr(2'd1, 32'h5A00_0042);
      wr(2'd2, 32'h5A00_0077);
      wr(2'd3, 32'h5A00_0099);
      rd(2'd2, v); chk("R9 addr 2 reads zero", v, 32'd0);
      rd(2'd3, v); chk("R9 addr 3 reads zero", v, 32'd0);
      rd(2'd0, v); chk("R9 stop untouched", v, 32'h0000_0300);
      rd(2'd1, v); chk("R9 count untouched", v, 32'h0000_0042);

      // R8: power-on reset mid-run clears the stop register
      @(negedge clk);
      por_n = 1'b0;
      #1 chk("R8 overflow low in por", {31'd0, overflow}, 32'd0);
      @(negedge clk);
      por_n = 1'b1;
      rd(2'd0, v); chk("R8 stop cleared by por", v, 32'd0);
      rd(2'd1, v); chk("R8 count cleared by por", v, 32'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule